// File: doc/BRIEF.md
# Video Sequencer Timing and Control

This block is the timing core of a planar display controller. A host programs it through two byte-wide ports. A write to the index port selects one of five internal registers, and the data port then reads or writes the selected register. From the master clock the block produces single-cycle enables for the dot clock and the character clock, plus the strobe that tells the pixel serializers to load a new word. It also produces a blanking request and a flag that shows whether the sequencer is running.

Two halt bits control the sequencer, and both must be 1 for it to run. One bit stops everything in the next cycle. The other lets the current character finish and then stops. While halted, the dot and load counters are held at zero, so a restart always begins on a character boundary.

The clocking register sets three things: the character width (8 or 9 dots), an optional halving of the dot rate, and the serializer load interval (1, 2 or 4 characters). Its screen-off bit raises the blank request, while all timing keeps running so that the sync logic downstream is not disturbed.

Top module: `vid_seq_ctrl`

## Requirements
- R1: A write with `host_addr`=0 stores the index, and a read with `host_addr`=0 returns it. Writes and reads with `host_addr`=1 access the register at that index. A read returns its data on `host_rdata` one clock after `host_rd`.
- R2: Only some bits of each register are stored, and every other bit reads as 0. The stored bits are: index 0 bits 1:0, index 1 bits 0, 2, 3, 4 and 5, index 2 bits 3:0, index 3 bits 5:0, index 4 bits 3:1.
- R3: An index of 5 or above reads as 0 on the data port, and a data write to it changes no register.
- R4: `running` rises one clock after index 0 holds bit0=1 and bit1=1. After reset every register is 0, so the block starts halted with all outputs at 0.
- R5: Clearing index 0 bit 0 stops `dot_en` and `running` at the next clock after the write.
- R6: Clearing index 0 bit 1 (with bit 0 still 1) keeps the sequencer running until the current character ends. `running` falls in the same cycle as the final `char_en` pulse.
- R7: With index 1 bit 3 = 1, `dot_en` pulses every second master clock. With bit 3 = 0, it pulses every master clock.
- R8: Index 1 bit 0 sets the character width. A value of 0 gives 9 dots and a value of 1 gives 8 dots. `char_en` pulses with the last dot of each character.
- R9: `ser_load` pulses once per character when index 1 bits 2 and 4 are both 0. It pulses once every 2 characters when bit 2 is 1 and bit 4 is 0. It pulses once every 4 characters when bit 4 is 1, whatever bit 2 holds.
- R10: After a restart, the first `dot_en` comes P cycles after `running` rises, and the first `ser_load` comes W·N·P cycles after it. Here P is the dot period, W is the dots per character and N is the load interval.
- R11: Index 1 bit 5 raises `blank_req`, and the dot, character and load timing continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 1 | Host port select: 0 selects the index port, 1 selects the data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| dot_en | output | 1 | Dot clock enable |
| char_en | output | 1 | Character clock enable |
| ser_load | output | 1 | Serializer load strobe |
| blank_req | output | 1 | Screen blank request |
| running | output | 1 | Sequencer running flag |

## Verification
The main sweep covers all 16 combinations of dot halving, character width and the two load-rate bits. Each combination starts from a halt, and the bench counts dot, character and load pulses over a window of exactly two load periods. It also records the cycle of the first load. A wrong count shows a wrong divider. A first load in the wrong cycle shows bad restart alignment, even when the period is right. The case with both rate bits set distinguishes the priority rule from an OR or a sum of the intervals. Separate runs cover each halt bit, the screen-off bit and a full read-back of all eight index values, and each of those runs tells apart a stop in the next cycle, a stop at the character end and timing that keeps running.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int REG_RESET = 0;
  localparam int REG_CLOCK = 1;

  localparam int B_ARST_N = 0;
  localparam int B_SRST_N = 1;
  localparam int B_DOT8   = 0;
  localparam int B_HALF   = 2;
  localparam int B_DIV2   = 3;
  localparam int B_QUART  = 4;
  localparam int B_SCROFF = 5;

  typedef struct packed {
    logic arst_n;
    logic srst_n;
    logic dot8;
    logic half;
    logic div2;
    logic quart;
    logic scr_off;
  } seq_cfg_t;

  function automatic logic [7:0] reg_mask(input int idx);
    case (idx)
      0:       return 8'h03;
      1:       return 8'h3D;
      2:       return 8'h0F;
      3:       return 8'h3F;
      4:       return 8'h0E;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/vseq_regs.sv
module vseq_regs
  import vseq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output seq_cfg_t          cfg
);
  localparam int IW = $clog2(NUM_REGS);

  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              hit;
  logic [IW-1:0]     sel;

  assign hit = idx_q < DATA_W'(NUM_REGS);
  assign sel = idx_q[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      host_rdata <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else begin
      if (host_wr && !host_addr) idx_q <= host_wdata;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (host_wr && host_addr && hit && (sel == IW'(i)))
          regs_q[i] <= host_wdata & DATA_W'(reg_mask(i));
      end
      if (host_rd) begin
        if (!host_addr)  host_rdata <= idx_q;
        else if (hit)    host_rdata <= regs_q[sel];
        else             host_rdata <= '0;
      end
    end
  end

  assign cfg.arst_n  = regs_q[REG_RESET][B_ARST_N];
  assign cfg.srst_n  = regs_q[REG_RESET][B_SRST_N];
  assign cfg.dot8    = regs_q[REG_CLOCK][B_DOT8];
  assign cfg.half    = regs_q[REG_CLOCK][B_HALF];
  assign cfg.div2    = regs_q[REG_CLOCK][B_DIV2];
  assign cfg.quart   = regs_q[REG_CLOCK][B_QUART];
  assign cfg.scr_off = regs_q[REG_CLOCK][B_SCROFF];
endmodule

// File: rtl/vseq_dotgen.sv
module vseq_dotgen #(
  parameter int DOTS_WIDE = 9,
  parameter int DOTS_NARROW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic stop_now,
  input  logic div2,
  input  logic dot8,
  output logic dot_tick,
  output logic char_tick
);
  localparam int CW = $clog2(DOTS_WIDE);

  logic          ph_q;
  logic [CW-1:0] dc_q;
  logic [CW-1:0] last;
  logic          live;

  assign live      = run && !stop_now;
  assign last      = dot8 ? CW'(DOTS_NARROW - 1) : CW'(DOTS_WIDE - 1);
  assign dot_tick  = live && (!div2 || ph_q);
  assign char_tick = dot_tick && (dc_q >= last);

  always_ff @(posedge clk) begin
    if (rst || !live) begin
      ph_q <= 1'b0;
      dc_q <= '0;
    end else begin
      ph_q <= div2 ? !ph_q : 1'b0;
      if (dot_tick) dc_q <= (dc_q >= last) ? '0 : dc_q + 1'b1;
    end
  end
endmodule

// File: rtl/vseq_loadgen.sv
module vseq_loadgen #(
  parameter int MAX_INTERVAL = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic stop_now,
  input  logic char_tick,
  input  logic half,
  input  logic quart,
  output logic load_tick
);
  localparam int LW = $clog2(MAX_INTERVAL);

  logic [LW-1:0] lc_q;
  logic [LW-1:0] last;

  // the quarter-rate bit outranks the half-rate bit
  assign last      = quart ? LW'(MAX_INTERVAL - 1) : (half ? LW'(1) : LW'(0));
  assign load_tick = char_tick && (lc_q >= last);

  always_ff @(posedge clk) begin
    if (rst || !run || stop_now) lc_q <= '0;
    else if (char_tick) lc_q <= (lc_q >= last) ? '0 : lc_q + 1'b1;
  end
endmodule

// File: rtl/vid_seq_ctrl.sv
module vid_seq_ctrl
  import vseq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dot_en,
  output logic              char_en,
  output logic              ser_load,
  output logic              blank_req,
  output logic              running
);
  seq_cfg_t cfg;
  logic     run_q;
  logic     dot_tick, char_tick, load_tick;
  logic     stop_now;
  logic     cfg_div2, cfg_arst_n;

  assign stop_now   = !cfg.arst_n;
  assign cfg_div2   = cfg.div2;
  assign cfg_arst_n = cfg.arst_n;

  vseq_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cfg(cfg)
  );

  vseq_dotgen u_dot (
    .clk(clk), .rst(rst), .run(run_q), .stop_now(stop_now),
    .div2(cfg.div2), .dot8(cfg.dot8),
    .dot_tick(dot_tick), .char_tick(char_tick)
  );

  vseq_loadgen u_load (
    .clk(clk), .rst(rst), .run(run_q), .stop_now(stop_now),
    .char_tick(char_tick), .half(cfg.half), .quart(cfg.quart),
    .load_tick(load_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      dot_en    <= 1'b0;
      char_en   <= 1'b0;
      ser_load  <= 1'b0;
      blank_req <= 1'b0;
    end else begin
      if (!cfg.arst_n)      run_q <= 1'b0;
      else if (!cfg.srst_n) run_q <= run_q && !char_tick;
      else                  run_q <= 1'b1;
      dot_en    <= dot_tick;
      char_en   <= char_tick;
      ser_load  <= load_tick;
      blank_req <= cfg.scr_off;
    end
  end

  assign running = run_q;
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk (
  input logic clk,
  input logic rst,
  input logic running,
  input logic dot_en,
  input logic char_en,
  input logic ser_load,
  input logic dot_tick,
  input logic cfg_div2,
  input logic cfg_arst_n
);
  a_r4_halted_quiet: assert property (@(posedge clk) disable iff (rst)
    (!running && !$past(running)) |-> !dot_en);

  a_r5_async_stop: assert property (@(posedge clk) disable iff (rst)
    !cfg_arst_n |=> !running);

  a_r6_sync_at_boundary: assert property (@(posedge clk) disable iff (rst)
    ($fell(running) && $past(cfg_arst_n)) |-> char_en);

  a_r7_half_rate: assert property (@(posedge clk) disable iff (rst)
    (dot_tick && cfg_div2) |=> (!dot_tick || !cfg_div2));

  a_r8_char_on_dot: assert property (@(posedge clk) disable iff (rst)
    char_en |-> dot_en);

  a_r9_load_on_char: assert property (@(posedge clk) disable iff (rst)
    ser_load |-> char_en);
endmodule

bind vid_seq_ctrl vseq_chk u_chk (
  .clk(clk), .rst(rst), .running(running), .dot_en(dot_en),
  .char_en(char_en), .ser_load(ser_load), .dot_tick(dot_tick),
  .cfg_div2(cfg_div2), .cfg_arst_n(cfg_arst_n)
);

// File: tb/vid_seq_ctrl_bench.sv
`timescale 1ns/1ps
module vid_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       dot_en, char_en, ser_load, blank_req, running;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vid_seq_ctrl u_vid_seq_ctrl (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dot_en(dot_en), .char_en(char_en), .ser_load(ser_load),
    .blank_req(blank_req), .running(running)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
    host_write(1'b0, idx);
    host_write(1'b1, val);
  endtask

  task automatic wait_running;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (running) break;
    end
  endtask

  // R7 R8 R9 R10: count pulses over two load periods from the restart
  task automatic sweep_one(input bit div2, input bit dot8, input bit half, input bit quart);
    int p, w, n, t, nd, nc, nl, first;
    p = div2 ? 2 : 1;
    w = dot8 ? 8 : 9;
    n = quart ? 4 : (half ? 2 : 1);
    t = 2 * w * n * p;
    set_reg(8'd0, 8'h00);
    set_reg(8'd1, {3'b000, quart, div2, half, 1'b0, dot8});
    set_reg(8'd0, 8'h03);
    wait_running();
    nd = 0; nc = 0; nl = 0; first = -1;
    for (int s = 1; s <= t; s++) begin
      @(negedge clk);
      if (dot_en) nd++;
      if (char_en) nc++;
      if (ser_load) begin
        nl++;
        if (first < 0) first = s;
      end
    end
    check("R7 dot count", nd, t / p);
    check("R8 char count", nc, 2 * n);
    check("R9 load count", nl, 2);
    check("R10 first load cycle", first, w * n * p);
  endtask

  initial begin
    logic [7:0] rd;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 reset running", running, 0);
    check("R4 reset dot_en", dot_en, 0);
    check("R4 reset blank", blank_req, 0);
    host_write(1'b0, 8'd1);
    host_read(1'b1, rd);
    check("R4 reset reg1", rd, 0);

    // R2 R3: write all ones everywhere, read back masks
    for (int i = 0; i < 8; i++) set_reg(8'(i), 8'hFF);
    for (int i = 0; i < 8; i++) begin
      int e;
      case (i)
        0: e = 8'h03; 1: e = 8'h3D; 2: e = 8'h0F; 3: e = 8'h3F; 4: e = 8'h0E;
        default: e = 0;
      endcase
      host_write(1'b0, 8'(i));
      host_read(1'b1, rd);
      check(i < 5 ? "R2 readback mask" : "R3 out of range read", rd, e);
    end
    // R1: index port reads back
    host_write(1'b0, 8'h5A);
    host_read(1'b0, rd);
    check("R1 index readback", rd, 8'h5A);
    // R3: write out-of-range index does not touch register 2
    set_reg(8'd6, 8'h00);
    set_reg(8'd250, 8'h00);
    host_write(1'b0, 8'd2);
    host_read(1'b1, rd);
    check("R3 ignored write", rd, 8'h0F);
    // R1: data write/read round trip
    set_reg(8'd3, 8'h25);
    host_read(1'b1, rd);
    check("R1 data readback", rd, 8'h25);

    for (int c = 0; c < 16; c++) sweep_one(c[3], c[2], c[1], c[0]);

    // R11: screen off blanks but timing continues
    sweep_one(1'b0, 1'b0, 1'b0, 1'b0);
    set_reg(8'd1, 8'h20);
    @(negedge clk);
    check("R11 blank_req", blank_req, 1);
    check("R11 still running", running, 1);
    cnt = 0;
    for (int s = 0; s < 18; s++) begin
      @(negedge clk);
      if (dot_en) cnt++;
    end
    check("R11 dots while blanked", cnt, 18);

    // R6: sync halt finishes the character
    set_reg(8'd1, 8'h00);
    set_reg(8'd0, 8'h03);
    repeat (4) @(negedge clk);
    set_reg(8'd0, 8'h01);
    for (int s = 0; s < 40; s++) begin
      if (!running) break;
      @(negedge clk);
    end
    check("R6 halted", running, 0);
    check("R6 char_en at halt", char_en, 1);
    cnt = 0;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      if (dot_en) cnt++;
    end
    check("R6 no dots after halt", cnt, 0);

    // R4: restart from sync halt
    set_reg(8'd0, 8'h03);
    wait_running();
    check("R4 running after both bits", running, 1);
    @(negedge clk);
    check("R10 first dot one cycle later", dot_en, 1);

    // R5: async halt stops next cycle
    repeat (3) @(negedge clk);
    host_write(1'b0, 8'd0);
    host_write(1'b1, 8'h02);
    cnt = 0;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      if (dot_en || running) cnt++;
    end
    check("R5 async halt quiet", cnt, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule